// File: doc/BRIEF.md
# Key-Gated Trim Byte Window

This block puts a small set of factory calibration bytes behind a key-protected gate and makes them readable over a simple byte-wide register bus. Software must first write a fixed key to an access control address to open the gate. It then picks one of two banks with a bank select register and reads the calibration bytes through a shared address window. Bank 1 holds a byte that combines a trim revision nibble with a gain correction nibble. Bank 0 holds a signed offset byte. All of these values are fixed by parameters at elaboration.

A chip version byte can always be read, whether the gate is open or closed. Writing any value other than the key closes the gate again. While the gate is closed, the trim addresses read as zero. Every read is registered: the data comes back one cycle after the request, together with a valid strobe.

Top module: `trim_gate`

## Requirements
- R1: After synchronous reset the gate is closed (address 0x88 reads 0x00) and bank 0 is selected (address 0xFE reads 0x01).
- R2: Writing 0xDA to address 0x88 opens the gate; while open, address 0x88 reads 0x01.
- R3: Writing any value other than 0xDA to address 0x88 closes the gate, whatever its earlier state.
- R4: Writing 0x01 to address 0xFE selects bank 0 and writing 0x02 selects bank 1. Address 0xFE reads back 0x01 or 0x02 for the current bank. Any other value written there leaves the bank unchanged.
- R5: With the gate open and bank 1 selected, address 0xF4 reads the trim revision parameter in bits [3:0] and the gain correction parameter in bits [7:4].
- R6: With the gate open and bank 0 selected, address 0xFD reads the signed offset parameter.
- R7: While the gate is closed, addresses 0xF4 and 0xFD read 0x00 in either bank.
- R8: Address 0x00 reads 0xC0 when the version parameter is 0 and 0xC1 when it is 1, whatever the gate and bank state.
- R9: Writes to addresses 0x00, 0xF4, 0xFD and to any unmapped address change nothing that can be read.
- R10: Any address other than 0x00, 0x88, 0xF4, 0xFD and 0xFE reads 0x00. A trim address read while the other bank is selected also reads 0x00.
- R11: `rd_valid` is high in exactly the cycle after a cycle in which `rd_en` was high, and `rd_data` carries that read's byte. When `rd_valid` is low, `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | High the cycle after a read request |

## Verification
The hardest case to reach is a wrong key written while the gate is already open. Reaching it means opening the gate with the key and then, from that open state, writing each of the other 255 byte values to the access control address. The bench does exactly this, re-opening the gate before every value, and it sweeps the bank select register the same way starting from each bank. The bench also visits all four gate and bank combinations and reads all 256 addresses in each one. Finally, it writes to every address other than the two control registers and reads the trim and version bytes back to confirm they have not changed.

// File: rtl/trim_gate_pkg.sv
package trim_gate_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_VERSION = 8'h00;
    localparam logic [ADDR_W-1:0] A_GATE    = 8'h88;
    localparam logic [ADDR_W-1:0] A_GAIN    = 8'hF4;
    localparam logic [ADDR_W-1:0] A_OFFSET  = 8'hFD;
    localparam logic [ADDR_W-1:0] A_BANK    = 8'hFE;

    localparam logic [DATA_W-1:0] GATE_KEY   = 8'hDA;
    localparam logic [DATA_W-1:0] CODE_BANK0 = 8'h01;
    localparam logic [DATA_W-1:0] CODE_BANK1 = 8'h02;
    localparam logic [DATA_W-1:0] GATE_OPEN_RB = 8'h01;

    typedef enum logic {BANK_LO = 1'b0, BANK_HI = 1'b1} bank_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] version_byte(input logic alt);
        return alt ? 8'hC1 : 8'hC0;
    endfunction

    function automatic logic [DATA_W-1:0] bank_code(input bank_t b);
        return (b == BANK_HI) ? CODE_BANK1 : CODE_BANK0;
    endfunction
endpackage

// File: rtl/trim_lock_ctrl.sv
module trim_lock_ctrl
    import trim_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     open_q
);
    logic hit;
    assign hit = req.wr && (req.addr == A_GATE);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (hit) begin
            open_q <= (req.wdata == GATE_KEY);
        end
    end
endmodule

// File: rtl/trim_bank_reg.sv
module trim_bank_reg
    import trim_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output bank_t    bank_q
);
    logic hit;
    assign hit = req.wr && (req.addr == A_BANK);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= BANK_LO;
        end else if (hit) begin
            if (req.wdata == CODE_BANK0) bank_q <= BANK_LO;
            else if (req.wdata == CODE_BANK1) bank_q <= BANK_HI;
        end
    end
endmodule

// File: rtl/trim_rd_path.sv
module trim_rd_path
    import trim_gate_pkg::*;
#(
    parameter bit         VERSION_ALT = 1'b1,
    parameter logic [3:0] TRIM_REV    = 4'h3,
    parameter logic [3:0] GAIN_CORR   = 4'h9,
    parameter logic [7:0] OFFSET_CORR = 8'hF6
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              open_q,
    input  bank_t             bank_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam logic [DATA_W-1:0] GAIN_BYTE = {GAIN_CORR, TRIM_REV};
    localparam logic [DATA_W-1:0] VER_BYTE  = version_byte(VERSION_ALT);

    logic [DATA_W-1:0] trim_hi, trim_lo, sel;

    // Each bank's window byte is enabled only by the gate and its own bank
    assign trim_hi = (open_q && bank_q == BANK_HI) ? GAIN_BYTE   : '0;
    assign trim_lo = (open_q && bank_q == BANK_LO) ? OFFSET_CORR : '0;

    always_comb begin
        unique case (req.addr)
            A_VERSION: sel = VER_BYTE;
            A_GATE:    sel = open_q ? GATE_OPEN_RB : '0;
            A_BANK:    sel = bank_code(bank_q);
            A_GAIN:    sel = trim_hi;
            A_OFFSET:  sel = trim_lo;
            default:   sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= req.rd;
            rd_data  <= req.rd ? sel : '0;
        end
    end
endmodule

// File: rtl/trim_gate.sv
module trim_gate
    import trim_gate_pkg::*;
#(
    parameter bit         VERSION_ALT = 1'b1,
    parameter logic [3:0] TRIM_REV    = 4'h3,
    parameter logic [3:0] GAIN_CORR   = 4'h9,
    parameter logic [7:0] OFFSET_CORR = 8'hF6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rd_data,
    output logic       rd_valid
);
    bus_req_t req;
    logic     gate_open;
    bank_t    bank_now;
    logic     bank_is_hi;

    assign req        = '{wr: wr_en, rd: rd_en, addr: addr, wdata: wdata};
    assign bank_is_hi = (bank_now == BANK_HI);

    trim_lock_ctrl u_lock (
        .clk(clk), .rst(rst), .req(req), .open_q(gate_open)
    );

    trim_bank_reg u_bank (
        .clk(clk), .rst(rst), .req(req), .bank_q(bank_now)
    );

    trim_rd_path #(
        .VERSION_ALT(VERSION_ALT), .TRIM_REV(TRIM_REV),
        .GAIN_CORR(GAIN_CORR), .OFFSET_CORR(OFFSET_CORR)
    ) u_rd (
        .clk(clk), .rst(rst), .req(req), .open_q(gate_open),
        .bank_q(bank_now), .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/trim_gate_chk.sv
module trim_gate_chk #(
    parameter bit         VERSION_ALT = 1'b1,
    parameter logic [3:0] TRIM_REV    = 4'h3,
    parameter logic [3:0] GAIN_CORR   = 4'h9
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rd_data,
    input logic       rd_valid,
    input logic       gate_open,
    input logic       bank_hi
);
    assert_reset_locked_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!gate_open && !bank_hi));

    assert_unlock_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h88 && wdata == 8'hDA) |=> gate_open);

    assert_relock_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h88 && wdata != 8'hDA) |=> !gate_open);

    assert_bank_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'hFE && wdata != 8'h01 && wdata != 8'h02) |=> $stable(bank_hi));

    assert_gain_byte_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 8'hF4 && gate_open && bank_hi) |=> (rd_data == {GAIN_CORR, TRIM_REV}));

    assert_locked_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == 8'hF4 || addr == 8'hFD) && !gate_open) |=> (rd_data == 8'h00));

    assert_version_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 8'h00) |=> (rd_data == (VERSION_ALT ? 8'hC1 : 8'hC0)));

    assert_valid_R11: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!rd_valid && rd_data == 8'h00));
endmodule

bind trim_gate trim_gate_chk #(
    .VERSION_ALT(VERSION_ALT), .TRIM_REV(TRIM_REV), .GAIN_CORR(GAIN_CORR)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .gate_open(gate_open), .bank_hi(bank_is_hi)
);

// File: tb/test_trim_gate.sv
module test_trim_gate;
    localparam bit         P_VER  = 1'b1;
    localparam logic [3:0] P_REV  = 4'h3;
    localparam logic [3:0] P_GAIN = 4'h9;
    localparam logic [7:0] P_OFF  = 8'hF6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    trim_gate #(
        .VERSION_ALT(P_VER), .TRIM_REV(P_REV), .GAIN_CORR(P_GAIN), .OFFSET_CORR(P_OFF)
    ) i_trim_gate (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [7:0] model(input logic [7:0] a, input bit open, input bit hi);
        case (a)
            8'h00:   return P_VER ? 8'hC1 : 8'hC0;
            8'h88:   return open ? 8'h01 : 8'h00;
            8'hFE:   return hi ? 8'h02 : 8'h01;
            8'hF4:   return (open && hi) ? {P_GAIN, P_REV} : 8'h00;
            8'hFD:   return (open && !hi) ? P_OFF : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d; logic v;
        rd(a, d, v);
        check(req, d, exp);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d; logic v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_check("R1 gate", 8'h88, 8'h00);
        rd_check("R1 bank", 8'hFE, 8'h01);

        // R11: idle outputs, then valid strobe with data
        @(negedge clk);
        check("R11 idle valid", {7'd0, rd_valid}, 8'h00);
        check("R11 idle data", rd_data, 8'h00);
        rd(8'h00, d, v);
        check("R11 valid", {7'd0, v}, 8'h01);
        check("R8 version", d, P_VER ? 8'hC1 : 8'hC0);
        @(negedge clk);
        check("R11 drop", {7'd0, rd_valid}, 8'h00);

        // R5 R6 R7 R8 R10: all addresses in every gate/bank state
        for (int o = 0; o < 2; o++) begin
            for (int h = 0; h < 2; h++) begin
                wr(8'h88, o ? 8'hDA : 8'h00);
                wr(8'hFE, h ? 8'h02 : 8'h01);
                for (int a = 0; a < 256; a++) begin
                    rd(a[7:0], d, v);
                    check("R5 R6 R7 R8 R10 sweep", d, model(a[7:0], o != 0, h != 0));
                end
            end
        end

        // R2 R3: every value from the open state
        for (int x = 0; x < 256; x++) begin
            wr(8'h88, 8'hDA);
            rd_check("R2 open", 8'h88, 8'h01);
            wr(8'h88, x[7:0]);
            rd_check("R3 value", 8'h88, (x[7:0] == 8'hDA) ? 8'h01 : 8'h00);
        end

        // R4: every value from each bank
        for (int h = 0; h < 2; h++) begin
            for (int x = 0; x < 256; x++) begin
                wr(8'hFE, h ? 8'h02 : 8'h01);
                wr(8'hFE, x[7:0]);
                rd_check("R4 bank", 8'hFE,
                    (x[7:0] == 8'h01) ? 8'h01 :
                    (x[7:0] == 8'h02) ? 8'h02 : (h ? 8'h02 : 8'h01));
            end
        end

        // R9: writes outside the control registers are ignored
        wr(8'h88, 8'hDA);
        wr(8'hFE, 8'h02);
        for (int a = 0; a < 256; a++) begin
            if (a != 8'h88 && a != 8'hFE) wr(a[7:0], a[7:0] ^ 8'hA5);
        end
        rd_check("R9 gate kept", 8'h88, 8'h01);
        rd_check("R9 bank kept", 8'hFE, 8'h02);
        rd_check("R9 gain", 8'hF4, {P_GAIN, P_REV});
        rd_check("R9 version", 8'h00, P_VER ? 8'hC1 : 8'hC0);
        rd_check("R9 unmapped", 8'h10, 8'h00);
        wr(8'hFE, 8'h01);
        rd_check("R9 offset", 8'hFD, P_OFF);

        // R1: reset from the open, bank-1 state
        wr(8'hFE, 8'h02);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_check("R1 gate after", 8'h88, 8'h00);
        rd_check("R1 bank after", 8'hFE, 8'h01);
        rd_check("R7 after reset", 8'hFD, 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule